// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a signal-processing datapath. Every cycle it can accept one command that acts on one of four extended-precision accumulators. The two signed 16-bit operands arrive together on separate ports, as they would from two independent data memories. A command can clear an accumulator, load it with a product, add a product to it or subtract a product from it. The work is split over two register stages. The first stage registers the product. The second stage folds that product into the selected accumulator. Commands can therefore be issued back to back on the same accumulator with no stall.

Each accumulator is 40 bits wide, which gives eight guard bits above the 32-bit product. A fractional mode treats the operands as Q15 values. In that mode the product is doubled to form a Q31 value, and the one case that cannot be represented, -1 times -1, is clamped. A read port returns one accumulator, one cycle after the request, as a 16-bit value. The value is either clamped to the signed 16-bit range or simply truncated, chosen per read. A sticky per-accumulator flag records every read that had to clamp.

Top module: `sat_mac`

## Requirements
- R1: While reset is low and after it is released, every accumulator holds zero, `ovf_flags` is all zeros and `rd_valid` is low.
- R2: Command code 3 (multiply-add) adds A×B to the selected accumulator. A read issued two or more cycles after the command cycle sees the new value.
- R3: Command code 4 (multiply-subtract) subtracts A×B from the selected accumulator.
- R4: Command code 2 loads the sign-extended product into the selected accumulator. Code 1 sets that accumulator to zero and clears its overflow flag. Codes 0, 5, 6 and 7 change nothing.
- R5: Commands can be issued on consecutive cycles, including several in a row on the same accumulator, and each one builds on the result of the one before it with no stall.
- R6: Accumulators are 40-bit two's complement. 256 full-scale products (0x8000×0x8000 = 2^30 each) sum to 2^38 without changing sign, and subtracting them again restores the exact value.
- R7: With `frac_mode` high at command time, the product is shifted left by one bit. The operand pair 0x8000×0x8000 instead yields 0x7FFFFFFF.
- R8: With `frac_mode` high at read time, the read value is bits [31:16] of the accumulator after 2^15 is added, so a half is rounded up. This value is clamped to 0x7FFF/0x8000 when `sat_en` is high.
- R9: With `frac_mode` low at read time, the read value is the accumulator itself. When `sat_en` is high it is clamped to the range 0x8000..0x7FFF. Otherwise its low 16 bits are returned.
- R10: A read with `sat_en` high that has to clamp sets the flag of that accumulator, and the flag stays set until a clear command reaches that accumulator. Reads with `sat_en` low never set a flag.
- R11: A command changes only the accumulator named by `acc_sel`.
- R12: `rd_valid` and `rd_data` are registered and follow `rd_en` by exactly one cycle. `rd_valid` is low in any cycle after one with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A command is present this cycle |
| op_code | input | 3 | 0 none, 1 clear, 2 load product, 3 multiply-add, 4 multiply-subtract |
| acc_sel | input | 2 | Accumulator targeted by the command |
| frac_mode | input | 1 | Q15 interpretation for both the command and the read of this cycle |
| opnd_a | input | 16 | First signed operand |
| opnd_b | input | 16 | Second signed operand |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Accumulator to read |
| sat_en | input | 1 | Clamp the read value (1) or truncate it (0) |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 16 | Read result |
| ovf_flags | output | 4 | Sticky clamp flag, one bit per accumulator |

## Verification
The checks assume that reset is applied from time zero with `op_valid` and `rd_en` held low. They also assume that a flag can only drop two cycles after a clear command was issued to that accumulator, which is true only if no other input path touches the flags. The stimulus changes inputs only at falling edges and leaves an idle cycle between a final command and any read that must see it, so each expected value follows directly from the two-stage timing. The operand corners (both operands at the minimum, rounding exactly at a half, sums that need the guard bits) are driven deliberately rather than left to chance.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_CLEAR = 3'd1,
        CMD_LOAD  = 3'd2,
        CMD_ADD   = 3'd3,
        CMD_SUB   = 3'd4
    } mac_cmd_e;
endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic              frac_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              p_valid,
    output mac_cmd_e          p_cmd,
    output logic [SEL_W-1:0]  p_sel,
    output logic [PROD_W-1:0] p_prod
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [PROD_W-1:0] PROD_TOP = {1'b0, {(PROD_W-1){1'b1}}};

    logic signed [PROD_W-1:0] raw_prod;
    logic [PROD_W-1:0]        aligned;
    logic                     legal;
    mac_cmd_e                 dec_cmd;

    // Signed full-width product, then optional Q15 alignment
    always_comb begin
        raw_prod = $signed(opnd_a) * $signed(opnd_b);
        if (!frac_mode)
            aligned = raw_prod;
        else if (opnd_a == MOST_NEG && opnd_b == MOST_NEG)
            aligned = PROD_TOP;
        else
            aligned = raw_prod <<< 1;
    end

    always_comb begin
        legal   = 1'b1;
        dec_cmd = CMD_IDLE;
        unique case (op_code)
            3'd1:    dec_cmd = CMD_CLEAR;
            3'd2:    dec_cmd = CMD_LOAD;
            3'd3:    dec_cmd = CMD_ADD;
            3'd4:    dec_cmd = CMD_SUB;
            default: legal = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_cmd   <= CMD_IDLE;
            p_sel   <= '0;
            p_prod  <= '0;
        end else begin
            p_valid <= op_valid && legal;
            p_cmd   <= dec_cmd;
            p_sel   <= acc_sel;
            p_prod  <= aligned;
        end
    end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
    import mac_pkg::*;
#(
    parameter int PROD_W  = 32,
    parameter int GUARD_W = 8,
    parameter int NUM_ACC = 4,
    parameter int SEL_W   = 2,
    localparam int ACC_W  = PROD_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_valid,
    input  mac_cmd_e          p_cmd,
    input  logic [SEL_W-1:0]  p_sel,
    input  logic [PROD_W-1:0] p_prod,
    output logic [ACC_W-1:0]  acc_q [NUM_ACC],
    output logic [NUM_ACC-1:0] clr_hit
);
    logic [ACC_W-1:0] prod_ext;

    assign prod_ext = {{GUARD_W{p_prod[PROD_W-1]}}, p_prod};

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        logic hit;
        assign hit        = p_valid && (p_sel == SEL_W'(g));
        assign clr_hit[g] = hit && (p_cmd == CMD_CLEAR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (hit) begin
                unique case (p_cmd)
                    CMD_CLEAR: acc_q[g] <= '0;
                    CMD_LOAD:  acc_q[g] <= prod_ext;
                    CMD_ADD:   acc_q[g] <= acc_q[g] + prod_ext;
                    CMD_SUB:   acc_q[g] <= acc_q[g] - prod_ext;
                    default:   acc_q[g] <= acc_q[g];
                endcase
            end
        end
    end
endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0]  acc_val,
    input  logic              frac_mode,
    input  logic              sat_en,
    output logic [DATA_W-1:0] out_val,
    output logic              clamped
);
    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] HI_LIM =
        {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] LO_LIM =
        {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [EXT_W-1:0] HALF_LSB =
        {{(EXT_W-DATA_W){1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] scaled;
    logic                    above;
    logic                    below;

    always_comb begin
        ext = {acc_val[ACC_W-1], acc_val};
        if (frac_mode)
            scaled = (ext + HALF_LSB) >>> DATA_W;
        else
            scaled = ext;
        above   = scaled > HI_LIM;
        below   = scaled < LO_LIM;
        clamped = sat_en && (above || below);
        if (sat_en && above)
            out_val = {1'b0, {(DATA_W-1){1'b1}}};
        else if (sat_en && below)
            out_val = {1'b1, {(DATA_W-1){1'b0}}};
        else
            out_val = scaled[DATA_W-1:0];
    end
endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8,
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = $clog2(NUM_ACC),
    localparam int PROD_W = 2 * DATA_W,
    localparam int ACC_W  = PROD_W + GUARD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_code,
    input  logic [SEL_W-1:0]   acc_sel,
    input  logic               frac_mode,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_sel,
    input  logic               sat_en,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_ACC-1:0] ovf_flags
);
    logic              p_valid;
    mac_cmd_e          p_cmd;
    logic [SEL_W-1:0]  p_sel;
    logic [PROD_W-1:0] p_prod;
    logic [ACC_W-1:0]  acc_q [NUM_ACC];
    logic [NUM_ACC-1:0] clr_hit;
    logic [DATA_W-1:0] rd_next;
    logic              rd_clamp;

    mac_mul_stage #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .frac_mode(frac_mode), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .p_valid(p_valid), .p_cmd(p_cmd), .p_sel(p_sel),
        .p_prod(p_prod)
    );

    mac_acc_bank #(.PROD_W(PROD_W), .GUARD_W(GUARD_W), .NUM_ACC(NUM_ACC),
                   .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .p_valid(p_valid), .p_cmd(p_cmd),
        .p_sel(p_sel), .p_prod(p_prod), .acc_q(acc_q), .clr_hit(clr_hit)
    );

    mac_readout #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_rd (
        .acc_val(acc_q[rd_sel]), .frac_mode(frac_mode), .sat_en(sat_en),
        .out_val(rd_next), .clamped(rd_clamp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= rd_next;
        end
    end

    // Sticky clamp flags; a clear arriving at the bank wins over a clamp
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ovf_flags[g] <= 1'b0;
            else if (clr_hit[g])
                ovf_flags[g] <= 1'b0;
            else if (rd_en && rd_sel == SEL_W'(g) && rd_clamp)
                ovf_flags[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk #(
    parameter int DATA_W  = 16,
    parameter int NUM_ACC = 4,
    parameter int SEL_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [2:0]         op_code,
    input logic [SEL_W-1:0]   acc_sel,
    input logic               rd_en,
    input logic [SEL_W-1:0]   rd_sel,
    input logic               sat_en,
    input logic               rd_valid,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_ACC-1:0] ovf_flags
);
    localparam logic [DATA_W-1:0] TOP_VAL = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] BOT_VAL = {1'b1, {(DATA_W-1){1'b0}}};

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R12
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R12

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_chk
        AST_FLAG_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2 && $rose(ovf_flags[g])) |->
            ($past(rd_en) && $past(sat_en) && $past(rd_sel) == SEL_W'(g))); // R10
        AST_FLAG_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && $fell(ovf_flags[g])) |->
            ($past(op_valid, 2) && $past(op_code, 2) == 3'd1 &&
             $past(acc_sel, 2) == SEL_W'(g))); // R4
        AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2 && $rose(ovf_flags[g])) |->
            (rd_data == TOP_VAL || rd_data == BOT_VAL)); // R9
    end
endmodule

bind sat_mac sat_mac_chk #(.DATA_W(DATA_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .rd_en(rd_en), .rd_sel(rd_sel), .sat_en(sat_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf_flags(ovf_flags)
);

// File: tb/sat_mac_tb.sv
module sat_mac_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [1:0]  acc_sel = 2'd0;
    logic        frac_mode = 1'b0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] opnd_b = 16'd0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic        sat_en = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [3:0]  ovf_flags;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sat_mac u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .frac_mode(frac_mode), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .rd_en(rd_en), .rd_sel(rd_sel), .sat_en(sat_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .ovf_flags(ovf_flags)
    );

    // rows: {a, b, frac, sat, expected}
    localparam logic [49:0] VEC [12] = '{
        {16'h0003, 16'h0004, 1'b0, 1'b1, 16'h000C},
        {16'hFFF9, 16'h0005, 1'b0, 1'b1, 16'hFFDD},
        {16'h012C, 16'h012C, 1'b0, 1'b1, 16'h7FFF},
        {16'h012C, 16'h012C, 1'b0, 1'b0, 16'h5F90},
        {16'hFED4, 16'h012C, 1'b0, 1'b1, 16'h8000},
        {16'hFFFF, 16'h0001, 1'b0, 1'b1, 16'hFFFF},
        {16'h4000, 16'h4000, 1'b1, 1'b1, 16'h2000},
        {16'h8000, 16'h8000, 1'b1, 1'b1, 16'h7FFF},
        {16'h8000, 16'h8000, 1'b1, 1'b0, 16'h8000},
        {16'h8000, 16'h4000, 1'b1, 1'b1, 16'hC000},
        {16'h0001, 16'h4000, 1'b1, 1'b1, 16'h0001},
        {16'h0001, 16'h3FFF, 1'b1, 1'b1, 16'h0000}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] code, input logic [1:0] sel,
                       input logic [15:0] a, input logic [15:0] b, input logic fr);
        op_valid = 1'b1; op_code = code; acc_sel = sel;
        opnd_a = a; opnd_b = b; frac_mode = fr;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
    endtask

    // one idle cycle lets the last command land, then a one-cycle read
    task automatic rd(input logic [1:0] sel, input logic sat, input logic fr,
                      output logic [15:0] val);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel; sat_en = sat; frac_mode = fr;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
        check("R12 rd_valid after request", {15'd0, rd_valid}, 16'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] got;
        repeat (3) @(negedge clk);
        check("R1 rd_valid in reset", {15'd0, rd_valid}, 16'd0);
        check("R1 flags in reset", {12'd0, ovf_flags}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), 1'b1, 1'b0, got);
            check("R1 accumulator zero", got, 16'h0000);
        end
        @(negedge clk);
        check("R12 rd_valid low when idle", {15'd0, rd_valid}, 16'd0);

        // vector table: load a product into acc0 and read it back
        for (int i = 0; i < 12; i++) begin
            logic [49:0] v;
            v = VEC[i];
            cmd(3'd1, 2'd0, 16'd0, 16'd0, 1'b0);
            cmd(3'd2, 2'd0, v[49:34], v[33:18], v[17]);
            rd(2'd0, v[16], v[17], got);
            if (i < 6)      check("R9 R4 integer readout", got, v[15:0]);
            else if (i < 10) check("R7 fractional product", got, v[15:0]);
            else             check("R8 rounding", got, v[15:0]);
        end

        // R3 multiply-subtract
        cmd(3'd1, 2'd1, 16'd0, 16'd0, 1'b0);
        cmd(3'd2, 2'd1, 16'd100, 16'd100, 1'b0);
        cmd(3'd4, 2'd1, 16'd30, 16'd30, 1'b0);
        rd(2'd1, 1'b1, 1'b0, got);
        check("R3 subtract", got, 16'h238C);

        // R5 / R2 back-to-back on one accumulator
        cmd(3'd1, 2'd2, 16'd0, 16'd0, 1'b0);
        for (int k = 1; k <= 5; k++)
            cmd(3'd3, 2'd2, 16'(k), 16'(k), 1'b0);
        cmd(3'd4, 2'd2, 16'd2, 16'd3, 1'b0);
        rd(2'd2, 1'b1, 1'b0, got);
        check("R5 R2 back-to-back sum", got, 16'h0031);

        // illegal codes do nothing
        cmd(3'd6, 2'd2, 16'd7, 16'd7, 1'b0);
        cmd(3'd0, 2'd2, 16'd7, 16'd7, 1'b0);
        rd(2'd2, 1'b1, 1'b0, got);
        check("R4 ignored codes", got, 16'h0031);

        // R11 other accumulators untouched
        rd(2'd3, 1'b1, 1'b0, got);
        check("R11 acc3 untouched", got, 16'h0000);
        rd(2'd1, 1'b1, 1'b0, got);
        check("R11 acc1 kept", got, 16'h238C);

        // R6 guard bits
        cmd(3'd1, 2'd0, 16'd0, 16'd0, 1'b0);
        for (int k = 0; k < 256; k++)
            cmd(3'd3, 2'd0, 16'h8000, 16'h8000, 1'b0);
        rd(2'd0, 1'b1, 1'b0, got);
        check("R6 large sum positive int", got, 16'h7FFF);
        rd(2'd0, 1'b1, 1'b1, got);
        check("R6 large sum positive frac", got, 16'h7FFF);
        for (int k = 0; k < 255; k++)
            cmd(3'd4, 2'd0, 16'h8000, 16'h8000, 1'b0);
        rd(2'd0, 1'b0, 1'b1, got);
        check("R6 exact remainder frac", got, 16'h4000);
        rd(2'd0, 1'b0, 1'b0, got);
        check("R6 exact remainder low bits", got, 16'h0000);

        // R10 sticky flags
        check("R10 flag after clamp", {12'd0, ovf_flags}, 16'h0001);
        cmd(3'd2, 2'd3, 16'h012C, 16'h012C, 1'b0);
        rd(2'd3, 1'b0, 1'b0, got);
        check("R9 wrap read", got, 16'h5F90);
        check("R10 wrap read sets no flag", {12'd0, ovf_flags}, 16'h0001);
        rd(2'd3, 1'b1, 1'b0, got);
        check("R10 flag on acc3", {12'd0, ovf_flags}, 16'h0009);
        cmd(3'd3, 2'd3, 16'd1, 16'd1, 1'b0);
        @(negedge clk);
        check("R10 flag sticky", {12'd0, ovf_flags}, 16'h0009);
        cmd(3'd1, 2'd0, 16'd0, 16'd0, 1'b0);
        @(negedge clk);
        check("R4 R10 clear drops flag", {12'd0, ovf_flags}, 16'h0008);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule